// File: doc/BRIEF.md
# Page Translation Cache with Global Entries

This block keeps a small, fully associative set of recently used virtual-page to physical-frame mappings. A lookup presents a virtual page number. Every stored tag is compared against it in parallel, and the block answers in the same cycle with a hit flag, the frame number and the page's protection flags (writable, user-accessible, dirty). When a lookup misses, an external page walker fetches the mapping and installs it through the refill port. No software takes part in this.

Three invalidation controls keep the cache coherent with the page tables. The first removes the entry for one page after its mapping has changed. The second handles an address-space switch: it removes every entry except those marked global, which map pages shared by all address spaces. The third clears the whole cache, global entries included, in a single cycle. A write lookup that hits a page whose dirty flag is still clear is reported as an update request rather than a hit. The walker can then set the dirty flag in memory and refill the entry.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, so every lookup misses, with `lk_hit`, `lk_upd`, `lk_pfn` and all flag outputs at 0.
- R2: A lookup is answered combinationally in the same cycle. On a hit, `lk_pfn`, `lk_wr`, `lk_usr` and `lk_dirty` carry the stored values of the matching entry. On a miss, all four are 0.
- R3: A refill presented in one cycle is visible to lookups from the next cycle on.
- R4: A refill whose page number is already stored overwrites that entry, so no page ever occupies two entries.
- R5: A refill of a new page goes to the lowest-numbered invalid entry. When every entry is valid, a round-robin pointer picks the victim. The pointer starts at entry 0 after reset and advances by one only when it is used.
- R6: A write lookup (`lk_write`=1) that matches an entry with dirty=0 gives `lk_hit`=0 and `lk_upd`=1. A read lookup of the same entry, or a write lookup of an entry with dirty=1, gives a normal hit.
- R7: A single-page invalidate removes only the entry with that page number.
- R8: An address-space switch removes every entry whose global flag is 0 and keeps entries whose global flag is 1.
- R9: A full flush removes every entry, global ones included, in one cycle.
- R10: A lookup of a page that an invalidate or flush removes in the same cycle returns a miss.
- R11: When a refill and an invalidate or flush occur in the same cycle, the invalidate acts on the old contents first and the refilled entry survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_write | input | 1 | Lookup is for a store |
| lk_hit | output | 1 | Translation found and usable |
| lk_upd | output | 1 | Write hit on a clean page; walker must set dirty |
| lk_pfn | output | PFN_W | Physical frame number on a hit |
| lk_wr | output | 1 | Page is writable |
| lk_usr | output | 1 | Page is user-accessible |
| lk_dirty | output | 1 | Page has been written |
| fill_valid | input | 1 | Install a walked translation |
| fill_vpn | input | VPN_W | Page number of the refill |
| fill_pfn | input | PFN_W | Frame number of the refill |
| fill_wr | input | 1 | Writable flag of the refill |
| fill_usr | input | 1 | User flag of the refill |
| fill_dirty | input | 1 | Dirty flag of the refill |
| fill_global | input | 1 | Global flag of the refill |
| inv_page | input | 1 | Invalidate the entry matching inv_vpn |
| inv_vpn | input | VPN_W | Page number to invalidate |
| inv_space | input | 1 | Address-space switch: drop non-global entries |
| inv_all | input | 1 | Drop every entry |

## Verification
The main lookup path is tried with reads and writes against clean and dirty entries, which separates normal hits from update requests. Lookups to absent pages check that a miss gives zeroed outputs. A refill of a page already present, followed by a single-page invalidate, shows whether a duplicate entry was left behind. Sixteen distinct refills followed by further refills show whether the victim was chosen from a free entry or from the round-robin pointer, and in which order. Lookups placed in the same cycle as each kind of invalidate, and refills placed in the same cycle as a flush, show which action takes precedence.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;

  typedef struct packed {
    logic wr;
    logic usr;
    logic dirty;
    logic global;
  } xc_flags_t;

  localparam int unsigned XC_FLAGS_W = $bits(xc_flags_t);

endpackage

// File: rtl/xlat_cache_cam.sv
module xlat_cache_cam #(
  parameter int unsigned N     = 16,
  parameter int unsigned KEY_W = 20,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][KEY_W-1:0] tags,
  input  logic [N-1:0]            valid,
  input  logic [KEY_W-1:0]        key,
  output logic [N-1:0]            match,
  output logic                    any,
  output logic [IDX_W-1:0]        idx
);

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == key);
  end

  assign any = |match;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/xlat_cache_victim.sv
module xlat_cache_victim #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid,
  input  logic             fill_fire,
  input  logic             tag_present,
  input  logic [IDX_W-1:0] tag_idx,
  output logic [IDX_W-1:0] victim
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] rr_q, rr_d;
  logic             rr_en;
  logic             free_any;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
    end
  end

  always_comb begin
    rr_en = 1'b0;
    if (tag_present)   victim = tag_idx;
    else if (free_any) victim = free_idx;
    else begin
      victim = rr_q;
      rr_en  = fill_fire;
    end
    rr_d = (rr_q == LAST) ? '0 : rr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rr_q <= '0;
    else if (rr_en) rr_q <= rr_d;
  end

  p_free_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire && !tag_present && free_any |-> !valid[victim]);

  p_rr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_fire && (&valid) && !tag_present |=> rr_q != $past(rr_q));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned PFN_W   = 20,
  parameter int unsigned ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             lk_write,
  output logic             lk_hit,
  output logic             lk_upd,
  output logic [PFN_W-1:0] lk_pfn,
  output logic             lk_wr,
  output logic             lk_usr,
  output logic             lk_dirty,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_wr,
  input  logic             fill_usr,
  input  logic             fill_dirty,
  input  logic             fill_global,
  input  logic             inv_page,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             inv_space,
  input  logic             inv_all
);

  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // Entry storage: only the valid bits carry a reset.
  logic [ENTRIES-1:0]            valid_q, valid_d;
  logic [ENTRIES-1:0][VPN_W-1:0] tag_q;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
  xc_flags_t [ENTRIES-1:0]       flg_q;

  logic [ENTRIES-1:0] m_lk, m_fill, m_inv, kill, lk_sel;
  logic               any_lk, any_fill, any_inv;
  logic [IDX_W-1:0]   idx_lk, idx_fill, idx_inv, vic_idx;
  logic [ENTRIES-1:0] wr_en;

  xlat_cache_cam #(.N(ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_cam_lk (
    .tags(tag_q), .valid(valid_q), .key(lk_vpn),
    .match(m_lk), .any(any_lk), .idx(idx_lk));

  xlat_cache_cam #(.N(ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_cam_fill (
    .tags(tag_q), .valid(valid_q), .key(fill_vpn),
    .match(m_fill), .any(any_fill), .idx(idx_fill));

  xlat_cache_cam #(.N(ENTRIES), .KEY_W(VPN_W), .IDX_W(IDX_W)) u_cam_inv (
    .tags(tag_q), .valid(valid_q), .key(inv_vpn),
    .match(m_inv), .any(any_inv), .idx(idx_inv));

  xlat_cache_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .fill_fire(fill_valid),
    .tag_present(any_fill), .tag_idx(idx_fill), .victim(vic_idx));

  // Entries removed this cycle by any invalidate source.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_kill
    assign kill[g] = inv_all
                   || (inv_space && !flg_q[g].global)
                   || (inv_page && m_inv[g]);
  end

  // Lookup: one-hot select of surviving matches.
  logic             sel_any;
  logic [PFN_W-1:0] sel_pfn;
  xc_flags_t        sel_flg;

  always_comb begin
    lk_sel  = m_lk & ~kill;
    sel_any = |lk_sel;
    sel_pfn = '0;
    sel_flg = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_sel[i]) begin
        sel_pfn = sel_pfn | pfn_q[i];
        sel_flg = sel_flg | flg_q[i];
      end
    end
  end

  logic needs_upd;
  assign needs_upd = lk_write && !sel_flg.dirty;

  always_comb begin
    lk_hit   = lk_valid && sel_any && !needs_upd;
    lk_upd   = lk_valid && sel_any && needs_upd;
    lk_pfn   = lk_hit ? sel_pfn : '0;
    lk_wr    = lk_hit && sel_flg.wr;
    lk_usr   = lk_hit && sel_flg.usr;
    lk_dirty = lk_hit && sel_flg.dirty;
  end

  // Next state: invalidate old contents, then place the refill.
  always_comb begin
    valid_d = valid_q & ~kill;
    wr_en   = '0;
    if (fill_valid) begin
      wr_en[vic_idx]   = 1'b1;
      valid_d[vic_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  xc_flags_t fill_flg;
  assign fill_flg = '{wr: fill_wr, usr: fill_usr, dirty: fill_dirty, global: fill_global};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        tag_q[g] <= fill_vpn;
        pfn_q[g] <= fill_pfn;
        flg_q[g] <= fill_flg;
      end
    end
  end

  // Assertions
  p_no_dup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_lk));

  p_fill_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> valid_q[$past(vic_idx)] && (tag_q[$past(vic_idx)] == $past(fill_vpn)));

  p_flush_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all && !fill_valid |=> valid_q == '0);

  p_space_keep_global_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inv_space && !fill_valid |=> $countones(valid_q) <= $countones($past(valid_q)));

  p_inv_race_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && inv_page && (lk_vpn == inv_vpn) |-> !lk_hit && !lk_upd);

  p_upd_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_upd |-> lk_write && !lk_hit);

  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_pfn == '0 && !lk_wr && !lk_usr && !lk_dirty);

endmodule

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;

  localparam int unsigned VW = 20;
  localparam int unsigned PW = 20;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lk_valid, lk_write;
  logic [VW-1:0] lk_vpn;
  logic          lk_hit, lk_upd, lk_wr, lk_usr, lk_dirty;
  logic [PW-1:0] lk_pfn;
  logic          fill_valid, fill_wr, fill_usr, fill_dirty, fill_global;
  logic [VW-1:0] fill_vpn;
  logic [PW-1:0] fill_pfn;
  logic          inv_page, inv_space, inv_all;
  logic [VW-1:0] inv_vpn;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk, .rst_n, .lk_valid, .lk_vpn, .lk_write, .lk_hit, .lk_upd, .lk_pfn,
    .lk_wr, .lk_usr, .lk_dirty, .fill_valid, .fill_vpn, .fill_pfn, .fill_wr,
    .fill_usr, .fill_dirty, .fill_global, .inv_page, .inv_vpn, .inv_space,
    .inv_all);

  typedef struct packed {
    logic          is_fill;
    logic [VW-1:0] vpn;
    logic [PW-1:0] pfn;
    logic          g, wr, usr, d;
    logic          wacc;
    logic          e_hit, e_upd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 20'h00050, 20'h00E63, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 20'h00050, 20'h00E63, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b0, 20'h00050, 20'h00E63, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{1'b1, 20'h00051, 20'h00700, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 20'h00051, 20'h00700, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b0, 20'h00051, 20'h00700, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b0, 20'h00052, 20'h00000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 20'h00051, 20'h00701, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 20'h00051, 20'h00701, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    '{1'b1, 20'hC0300, 20'h012F0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 20'hC0300, 20'h012F0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b0, 20'h00050, 20'h00E63, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
  };

  task automatic idle();
    lk_valid = 0; lk_write = 0; lk_vpn = '0;
    fill_valid = 0; fill_vpn = '0; fill_pfn = '0;
    fill_wr = 0; fill_usr = 0; fill_dirty = 0; fill_global = 0;
    inv_page = 0; inv_vpn = '0; inv_space = 0; inv_all = 0;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Combinational lookup, sampled 1 ns after the falling edge.
  task automatic look(input logic [VW-1:0] v, input bit w, input bit e_hit,
                      input bit e_upd, input logic [PW-1:0] e_pfn,
                      input logic [2:0] e_flg, input string req);
    @(negedge clk); idle();
    lk_valid = 1; lk_vpn = v; lk_write = w;
    #1;
    chk(lk_hit === e_hit, {req, " hit"}, 32'(lk_hit), 32'(e_hit));
    chk(lk_upd === e_upd, {req, " upd"}, 32'(lk_upd), 32'(e_upd));
    chk(lk_pfn === (e_hit ? e_pfn : '0), {req, " pfn"}, 32'(lk_pfn),
        32'(e_hit ? e_pfn : '0));
    chk({lk_wr, lk_usr, lk_dirty} === (e_hit ? e_flg : 3'b000), {req, " flags"},
        32'({lk_wr, lk_usr, lk_dirty}), 32'(e_hit ? e_flg : 3'b000));
  endtask

  task automatic fill(input logic [VW-1:0] v, input logic [PW-1:0] p,
                      input bit g, input bit w, input bit u, input bit d);
    @(negedge clk); idle();
    fill_valid = 1; fill_vpn = v; fill_pfn = p;
    fill_global = g; fill_wr = w; fill_usr = u; fill_dirty = d;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: empty after reset
    look(20'h00000, 0, 0, 0, '0, 3'b000, "R1");
    look(20'h00050, 1, 0, 0, '0, 3'b000, "R1");

    // Vector table: R2 R3 R4 R6
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].is_fill)
        fill(VEC[i].vpn, VEC[i].pfn, VEC[i].g, VEC[i].wr, VEC[i].usr, VEC[i].d);
      else
        look(VEC[i].vpn, VEC[i].wacc, VEC[i].e_hit, VEC[i].e_upd, VEC[i].pfn,
             {VEC[i].wr, VEC[i].usr, VEC[i].d}, "R2/R3/R4/R6 vector");
    end

    // R10: lookup during a page invalidate of the same page
    @(negedge clk); idle();
    lk_valid = 1; lk_vpn = 20'h00051; inv_page = 1; inv_vpn = 20'h00051;
    #1 chk(!lk_hit && !lk_upd, "R10 page race", 32'(lk_hit), 0);
    // R4 + R7: overwritten page had one entry; neighbour untouched
    look(20'h00051, 0, 0, 0, '0, 3'b000, "R4 R7 removed");
    look(20'h00050, 0, 1, 0, 20'h00E63, 3'b111, "R7 neighbour");

    // R10 + R8: lookup of a non-global page during a space switch
    @(negedge clk); idle();
    lk_valid = 1; lk_vpn = 20'h00050; inv_space = 1;
    #1 chk(!lk_hit, "R10 space race", 32'(lk_hit), 0);
    look(20'h00050, 0, 0, 0, '0, 3'b000, "R8 non-global gone");
    look(20'hC0300, 0, 1, 0, 20'h012F0, 3'b001, "R8 global kept");

    // R9: full flush drops the global entry
    @(negedge clk); idle(); inv_all = 1;
    look(20'hC0300, 0, 0, 0, '0, 3'b000, "R9");

    // R5: fill all sixteen entries, then overflow
    for (int i = 0; i < 16; i++) fill(20'h00100 + VW'(i), 20'h00200 + PW'(i), 0, 1, 1, 1);
    look(20'h0010F, 0, 1, 0, 20'h0020F, 3'b111, "R5 full set");
    fill(20'h001FF, 20'h00AAA, 0, 1, 1, 1);
    look(20'h00100, 0, 0, 0, '0, 3'b000, "R5 rr evicts entry 0");
    look(20'h00101, 0, 1, 0, 20'h00201, 3'b111, "R5 entry 1 kept");
    look(20'h001FF, 0, 1, 0, 20'h00AAA, 3'b111, "R5 new entry");
    @(negedge clk); idle(); inv_page = 1; inv_vpn = 20'h00105;
    fill(20'h001FD, 20'h00BBB, 0, 1, 1, 1);
    look(20'h00101, 0, 1, 0, 20'h00201, 3'b111, "R5 free slot preferred");
    look(20'h001FD, 0, 1, 0, 20'h00BBB, 3'b111, "R5 free slot used");
    fill(20'h001FE, 20'h00CCC, 0, 1, 1, 1);
    look(20'h00101, 0, 0, 0, '0, 3'b000, "R5 rr advanced to 1");
    look(20'h00102, 0, 1, 0, 20'h00202, 3'b111, "R5 entry 2 kept");

    // R11: refill together with a full flush
    @(negedge clk); idle();
    inv_all = 1; fill_valid = 1; fill_vpn = 20'h00300; fill_pfn = 20'h00321;
    fill_wr = 1; fill_usr = 0; fill_dirty = 1;
    look(20'h00300, 1, 1, 0, 20'h00321, 3'b101, "R11 refill survives");
    look(20'h00102, 0, 0, 0, '0, 3'b000, "R11 old flushed");

    @(negedge clk); idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule